// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (256 x 8)

This block models a small serial EEPROM on a two-wire bus with clock (SCL) and data (SDA) lines. It holds 256 bytes in registers. It watches the two bus lines, which are oversampled by the system clock, and pulls SDA low through an open-drain enable whenever it acknowledges or sends a zero bit. A master reaches it through a control byte. That byte carries a fixed 4-bit device type, three strap bits that let up to eight such devices share one bus, and a read/write flag.

Three transfers are supported:
- A byte write: control byte, word address, then data.
- A random read: a write-type control byte and word address, then a repeated START and a read-type control byte.
- A current-address read: a read-type control byte alone, which uses an internal pointer.

Further data bytes in a write are stored at consecutive addresses, as a page. The block then models a program cycle whose length grows with the number of bytes written. While that cycle runs, the block refuses every control byte, so a master can poll for completion.

Both lines pass through a synchroniser and a persistence filter before START, STOP or clock edges are decoded. Outgoing data changes only a fixed number of cycles after SCL has fallen.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset, sda_oe_o is low, every one of the 256 locations reads 0 and the word pointer is 0.
- R2: The control byte is matched when bits 7:4 equal 1010 and bits 3:1 equal strap_i (bit 0 = 1 for read, 0 for write). A match is acknowledged by holding SDA low in the ninth clock. A mismatch is not acknowledged, and SDA stays released with array and pointer untouched until the next START.
- R3: In a write, the slave acknowledges the control byte, the word address and each data byte, and stores the data byte at that address.
- R4: In a read, the slave sends the byte at the pointer MSB first, one bit per SCL clock.
- R5: The pointer is loaded by the word address and advances by one after every byte read or written, wrapping from 255 to 0. A current-address read returns the location after the last one accessed.
- R6: A master acknowledge after a read byte makes the slave send the next location. A master no-acknowledge ends the read with SDA released.
- R7: Data bytes after the first in a write go to consecutive addresses. A program cycle of N x BUSY_CYC clocks starts at the STOP or START that ends the write, where N is the count of data bytes, saturating at PAGE_MAX. During it, every control byte is refused.
- R8: Each line is synchronised through two flops, and its filtered level changes only after the new level has persisted for FILT_CYC clocks. Shorter pulses on SCL or SDA create no bit, START or STOP.
- R9: sda_oe_o changes only HOLD_CYC or more clocks after a falling edge of SCL, and never while SCL is high, except when a START or STOP releases it.
- R10: A START or STOP is recognised in any state and discards a partial byte. A STOP before a data byte completes leaves memory unchanged and starts no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| strap_i | input | 3 | Device select straps compared with control byte bits 3:1 |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
A wrong internal state shows at the ports within one bus byte. A bad bit counter or a missed clock edge shifts the acknowledge slot, so the master samples a released SDA in the ninth clock. A corrupted pointer or array entry shows up as a wrong byte on the very next current-address or sequential read. A program timer loaded with the wrong length shows only at the next control byte. That byte is then acknowledged when it should be refused, or the reverse, so the bench probes it both right after a page write and after the expected window. A filter or hold-delay fault shows as an extra or missing bit, or as an SDA change too close to the SCL edge. Both are caught within the same transfer.

// File: rtl/ee_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the two-wire EEPROM slave.
// Assumes one word-address byte and byte-wide storage.
package ee_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam logic [3:0]  TYPE_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } ee_state_e;
endpackage

// File: rtl/ee_glitch_filter.sv
`timescale 1ns/1ps
// Two-flop synchroniser followed by a persistence filter.
// The filtered level follows the input only after the new level has
// been seen for FILT_CYC consecutive clocks. Assumes FILT_CYC >= 2.
module ee_glitch_filter #(
    parameter int unsigned FILT_CYC = 4,
    parameter logic        RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    logic          s1_q, s2_q, lvl_q;
    logic [CW-1:0] run_q;

    // Synchronise the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
        end
    end

    // Count how long the synchronised level has differed from the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= RST_VAL;
            run_q <= '0;
        end else if (s2_q == lvl_q) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_CYC - 1)) begin
            lvl_q <= s2_q;
            run_q <= '0;
        end else begin
            run_q <= run_q + CW'(1);
        end
    end

    assign line_o = lvl_q;

    // R8: a new filtered level was present at the synchroniser for two clocks at least.
    a_r8_filter_persist: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> ($past(s2_q, 1) == lvl_q) && ($past(s2_q, 2) == lvl_q));
endmodule

// File: rtl/ee_bus_cond.sv
`timescale 1ns/1ps
// Decodes START, STOP and SCL edges from the filtered bus lines.
// Assumes both inputs are already synchronous and glitch free.
module ee_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_d, sda_d;

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f_i;
            sda_d <= sda_f_i;
        end
    end

    // SDA edges while SCL stays high are bus conditions; SCL edges clock bits.
    always_comb begin
        start_o = scl_f_i & scl_d & sda_d & ~sda_f_i;
        stop_o  = scl_f_i & scl_d & ~sda_d & sda_f_i;
        rise_o  = scl_f_i & ~scl_d;
        fall_o  = ~scl_f_i & scl_d;
    end
endmodule

// File: rtl/ee_sda_hold.sv
`timescale 1ns/1ps
// Applies the requested SDA drive only HOLD_CYC clocks after each
// falling SCL edge, so data never moves near the edge. An abort
// (START/STOP) releases the line at once. Assumes HOLD_CYC >= 2.
module ee_sda_hold #(
    parameter int unsigned HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic abort_i,
    input  logic want_i,
    output logic oe_o
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] dly_q;

    // Delay counter and output register for the drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
            oe_o  <= 1'b0;
        end else if (abort_i) begin
            dly_q <= '0;
            oe_o  <= 1'b0;
        end else if (fall_i) begin
            dly_q <= HW'(HOLD_CYC);
        end else if (dly_q != '0) begin
            dly_q <= dly_q - HW'(1);
            if (dly_q == HW'(1)) begin
                oe_o <= want_i;
            end
        end
    end

    // R9: the drive enable does not move in the clock right after an SCL fall.
    a_r9_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i && !abort_i |=> $stable(oe_o));
endmodule

// File: rtl/ee_prog_timer.sv
`timescale 1ns/1ps
// Program-cycle timer: busy for nbytes x BUSY_CYC clocks after a go
// pulse with a non-zero byte count.
module ee_prog_timer #(
    parameter int unsigned BUSY_CYC = 20000,
    parameter int unsigned PAGE_MAX = 16,
    localparam int unsigned NW = $clog2(PAGE_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [NW-1:0] nbytes_i,
    output logic          busy_o
);
    localparam int unsigned TW = $clog2(BUSY_CYC * PAGE_MAX + 1);

    logic [TW-1:0] left_q;

    // Load the scaled duration on go, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (go_i && nbytes_i != '0) begin
            left_q <= TW'(nbytes_i) * TW'(BUSY_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - TW'(1);
        end
    end

    assign busy_o = (left_q != '0);

    // R7: a finished write with data makes the device busy on the next clock.
    a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        go_i && nbytes_i != '0 |=> busy_o);
endmodule

// File: rtl/eeprom_2w_slave.sv
`timescale 1ns/1ps
// Two-wire serial EEPROM slave with 256 x 8 register storage.
// Filters SCL/SDA, decodes bus conditions, runs the byte protocol,
// holds the word pointer and models the program-cycle busy time.
// Assumes the bus clock's low and high phases each exceed
// 2 + FILT_CYC + HOLD_CYC system clocks.
module eeprom_2w_slave #(
    parameter int unsigned FILT_CYC = 4,
    parameter int unsigned HOLD_CYC = 8,
    parameter int unsigned BUSY_CYC = 20000,
    parameter int unsigned PAGE_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);
    import ee_pkg::*;

    localparam int unsigned NW = $clog2(PAGE_MAX + 1);

    logic [1:0] raw_w, filt_w;
    logic       scl_f, sda_f;
    logic       cond_start, cond_stop, scl_rise, scl_fall;
    logic       busy, want_oe, ctrl_match;

    ee_state_e         st, nxt;
    logic [3:0]        bcnt;
    logic [WORD_W-1:0] shreg, txreg;
    logic [ADDR_W-1:0] ptr;
    logic [NW-1:0]     nwr;
    logic              mack;
    logic [WORD_W-1:0] mem [DEPTH];

    assign raw_w = {sda_i, scl_i};

    // One filter per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_filt
        ee_glitch_filter #(
            .FILT_CYC (FILT_CYC),
            .RST_VAL  (1'b1)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_w[g]),
            .line_o (filt_w[g])
        );
    end

    assign scl_f = filt_w[0];
    assign sda_f = filt_w[1];

    ee_bus_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f_i (scl_f),
        .sda_f_i (sda_f),
        .start_o (cond_start),
        .stop_o  (cond_stop),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    ee_prog_timer #(
        .BUSY_CYC (BUSY_CYC),
        .PAGE_MAX (PAGE_MAX)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (cond_start | cond_stop),
        .nbytes_i (nwr),
        .busy_o   (busy)
    );

    // Requested SDA drive for the current bit slot.
    always_comb begin
        unique case (st)
            ST_ACK:   want_oe = 1'b1;
            ST_RDATA: want_oe = ~txreg[WORD_W-1];
            default:  want_oe = 1'b0;
        endcase
    end

    ee_sda_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (scl_fall),
        .abort_i (cond_start | cond_stop),
        .want_i  (want_oe),
        .oe_o    (sda_oe_o)
    );

    assign ctrl_match = (shreg[WORD_W-1:1] == {TYPE_CODE, strap_i});

    // Byte protocol, word pointer, page counter and storage array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            nxt   <= ST_IDLE;
            bcnt  <= '0;
            shreg <= '0;
            txreg <= '0;
            ptr   <= '0;
            nwr   <= '0;
            mack  <= 1'b0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= '0;
            end
        end else if (cond_start) begin
            st   <= ST_CTRL;
            bcnt <= '0;
            nwr  <= '0;
        end else if (cond_stop) begin
            st   <= ST_IDLE;
            bcnt <= '0;
            nwr  <= '0;
        end else begin
            unique case (st)
                ST_CTRL, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && bcnt != 4'd8) begin
                        shreg <= {shreg[WORD_W-2:0], sda_f};
                        bcnt  <= bcnt + 4'd1;
                    end else if (scl_fall && bcnt == 4'd8) begin
                        bcnt <= '0;
                        if (st == ST_CTRL) begin
                            if (ctrl_match && !busy) begin
                                st  <= ST_ACK;
                                nxt <= shreg[0] ? ST_RDATA : ST_WADDR;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (st == ST_WADDR) begin
                            ptr <= shreg;
                            st  <= ST_ACK;
                            nxt <= ST_WDATA;
                        end else begin
                            mem[ptr] <= shreg;
                            ptr      <= ptr + ADDR_W'(1);
                            if (nwr != NW'(PAGE_MAX)) begin
                                nwr <= nwr + NW'(1);
                            end
                            st  <= ST_ACK;
                            nxt <= ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        st   <= nxt;
                        bcnt <= '0;
                        if (nxt == ST_RDATA) begin
                            txreg <= mem[ptr];
                            ptr   <= ptr + ADDR_W'(1);
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bcnt == 4'd7) begin
                            st   <= ST_RACK;
                            bcnt <= '0;
                        end else begin
                            txreg <= {txreg[WORD_W-2:0], 1'b0};
                            bcnt  <= bcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_f;
                    end else if (scl_fall) begin
                        if (mack) begin
                            st    <= ST_RDATA;
                            txreg <= mem[ptr];
                            ptr   <= ptr + ADDR_W'(1);
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R10: a START always restarts control-byte reception.
    a_r10_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cond_start |=> st == ST_CTRL);

    // R10: a STOP always returns the protocol to idle.
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cond_stop |=> st == ST_IDLE);

    // R7: a control byte ending while the program timer runs is refused.
    a_r7_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        busy && st == ST_CTRL && scl_fall && bcnt == 4'd8 |=> st == ST_IDLE);

    // R2: SDA is never pulled while the slave is idle.
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> st != ST_IDLE);
endmodule

// File: tb/test_eeprom_2w_slave.sv
`timescale 1ns/1ps
// Scoreboard bench: master tasks push expected bytes and ack bits,
// a monitor pops them as the bus returns results.
module test_eeprom_2w_slave;
    localparam int unsigned FILT = 4;
    localparam int unsigned HOLD = 8;
    localparam int unsigned BUSY = 400;
    localparam int H = 40;
    localparam logic [7:0] CW = 8'hAA;
    localparam logic [7:0] CR = 8'hAB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_i = 1'b1;
    logic       msda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_oe_o;
    logic       line;

    int tests = 0;
    int fails = 0;

    string      tq[$];
    logic [7:0] vq[$];
    logic [7:0] obs;
    event       obs_ev;

    always #10 clk = ~clk;

    assign line = msda & ~sda_oe_o;

    eeprom_2w_slave #(
        .FILT_CYC (FILT),
        .HOLD_CYC (HOLD),
        .BUSY_CYC (BUSY),
        .PAGE_MAX (16)
    ) i_eeprom_2w_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe_o)
    );

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Monitor: compare each observed result with the oldest expectation.
    initial begin
        forever begin
            @(obs_ev);
            if (vq.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL scoreboard-empty actual=%02h expected=none", obs);
            end else begin
                check(tq.pop_front(), obs, vq.pop_front());
            end
        end
    end

    // R9 watcher: SDA drive changes only well after SCL has fallen.
    int   since_fall = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (scl_prev && !scl_i) since_fall = 0;
        else since_fall++;
        if (rst_n && sda_oe_o !== oe_prev) begin
            tests++;
            if (since_fall < int'(HOLD) || scl_i) begin
                fails++;
                $display("FAIL R9 hold actual=%0d cycles scl=%0b expected>=%0d scl=0",
                         since_fall, scl_i, HOLD);
            end
        end
        scl_prev = scl_i;
        oe_prev  = sda_oe_o;
    end

    task automatic expect_item(input string tag, input logic [7:0] v);
        tq.push_back(tag);
        vq.push_back(v);
    endtask

    task automatic report(input logic [7:0] v);
        obs = v;
        ->obs_ev;
        #1;
    endtask

    task automatic bus_start();
        scl_i = 1'b0; wcyc(5);
        msda = 1'b1; wcyc(H);
        scl_i = 1'b1; wcyc(H);
        msda = 1'b0; wcyc(H);
        scl_i = 1'b0;
    endtask

    task automatic bus_stop();
        wcyc(5);
        msda = 1'b0; wcyc(H);
        scl_i = 1'b1; wcyc(H);
        msda = 1'b1; wcyc(H);
    endtask

    task automatic write_bit(input logic b, input bit glitch);
        wcyc(5);
        msda = b;
        if (glitch) begin
            wcyc(15); scl_i = 1'b1; wcyc(2); scl_i = 1'b0; wcyc(H - 22);
        end else begin
            wcyc(H - 5);
        end
        scl_i = 1'b1;
        wcyc(H / 2);
        if (glitch) begin
            msda = ~b; wcyc(2); msda = b; wcyc(H / 2 - 2);
        end else begin
            wcyc(H / 2);
        end
        scl_i = 1'b0;
    endtask

    task automatic read_bit(output logic b);
        wcyc(5);
        msda = 1'b1; wcyc(H - 5);
        scl_i = 1'b1; wcyc(H / 2);
        b = line; wcyc(H / 2);
        scl_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic exp_nack, input string tag,
                             input bit glitch);
        logic a;
        expect_item(tag, {7'd0, exp_nack});
        for (int i = 7; i >= 0; i--) write_bit(d[i], glitch);
        read_bit(a);
        report({7'd0, a});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit mack, input string tag);
        logic [7:0] d;
        logic b;
        expect_item(tag, exp);
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            d[i] = b;
        end
        report(d);
        write_bit(~mack, 1'b0);
    endtask

    task automatic byte_write(input logic [7:0] a, input logic [7:0] d, input bit glitch,
                              input string tag);
        bus_start();
        send_byte(CW, 1'b0, {tag, " ctrl ack"}, glitch);
        send_byte(a, 1'b0, {tag, " addr ack"}, glitch);
        send_byte(d, 1'b0, {tag, " data ack"}, glitch);
        bus_stop();
        wcyc(int'(BUSY) + 200);
    endtask

    task automatic cur_read(input logic [7:0] exp, input string tag);
        bus_start();
        send_byte(CR, 1'b0, {tag, " ctrl ack"}, 1'b0);
        recv_byte(exp, 1'b0, {tag, " data"});
        bus_stop();
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, input logic [7:0] e0,
                             input logic [7:0] e1, input logic [7:0] e2, input string tag);
        logic [7:0] ev [3];
        ev[0] = e0; ev[1] = e1; ev[2] = e2;
        bus_start();
        send_byte(CW, 1'b0, {tag, " ctrl ack"}, 1'b0);
        send_byte(a, 1'b0, {tag, " addr ack"}, 1'b0);
        bus_start();
        send_byte(CR, 1'b0, {tag, " rd ctrl ack"}, 1'b0);
        for (int i = 0; i < n; i++) recv_byte(ev[i], (i != n - 1), {tag, " data"});
        bus_stop();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        wcyc(10);
        check("R1 reset sda_oe", {7'd0, sda_oe_o}, 8'h00);
        rst_n = 1'b1;
        wcyc(20);
        check("R1 released after reset", {7'd0, sda_oe_o}, 8'h00);

        // R1 R5: cleared array, pointer at 0.
        cur_read(8'h00, "R1 R5 read after reset");

        // R3: byte writes.
        byte_write(8'h10, 8'h3C, 1'b0, "R3 write 10");
        byte_write(8'h11, 8'hC3, 1'b0, "R3 write 11");

        // R4: random read, then R5 current read follows on.
        rand_read(8'h10, 1, 8'h3C, 8'h00, 8'h00, "R4 random 10");
        cur_read(8'hC3, "R5 current after 10");

        // R7: page write, refused while busy, then sequential readback (R6).
        bus_start();
        send_byte(CW, 1'b0, "R7 page ctrl ack", 1'b0);
        send_byte(8'h20, 1'b0, "R7 page addr ack", 1'b0);
        send_byte(8'h11, 1'b0, "R7 page d0 ack", 1'b0);
        send_byte(8'h22, 1'b0, "R7 page d1 ack", 1'b0);
        send_byte(8'h33, 1'b0, "R7 page d2 ack", 1'b0);
        bus_stop();
        bus_start();
        send_byte(CW, 1'b1, "R7 busy refuse", 1'b0);
        bus_stop();
        wcyc(3 * int'(BUSY) + 300);
        rand_read(8'h20, 3, 8'h11, 8'h22, 8'h33, "R6 R7 page readback");

        // R5: wrap from 255 to 0 in a sequential read.
        byte_write(8'hFF, 8'hA5, 1'b0, "R5 write FF");
        byte_write(8'h01, 8'h6E, 1'b0, "R5 write 01");
        byte_write(8'h02, 8'h99, 1'b0, "R5 write 02");
        rand_read(8'hFE, 3, 8'h00, 8'hA5, 8'h00, "R5 R6 wrap");
        cur_read(8'h6E, "R5 current after wrap");

        // R2: foreign strap value ignored; pointer keeps its place.
        bus_start();
        send_byte(8'hA0, 1'b1, "R2 mismatch nack", 1'b0);
        send_byte(8'h55, 1'b1, "R2 line stays released", 1'b0);
        bus_stop();
        cur_read(8'h99, "R2 pointer untouched");

        // R10: STOP inside a data byte writes nothing and starts no busy time.
        byte_write(8'h40, 8'h5A, 1'b0, "R10 setup 40");
        bus_start();
        send_byte(CW, 1'b0, "R10 ctrl ack", 1'b0);
        send_byte(8'h40, 1'b0, "R10 addr ack", 1'b0);
        for (int i = 7; i >= 4; i--) write_bit(1'(8'h77 >> i), 1'b0);
        bus_stop();
        cur_read(8'h5A, "R10 no write, no busy");

        // R8: glitches on both lines during a write have no effect.
        byte_write(8'h50, 8'h96, 1'b1, "R8 glitched write");
        rand_read(8'h50, 1, 8'h96, 8'h00, 8'h00, "R8 glitched readback");

        wcyc(100);
        check("scoreboard drained", 8'(vq.size()), 8'h00);
        finish_run();
    end
endmodule